// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block drives the command side of a single-rank SDRAM on a 32-bit data bus from reset until the memory is usable, and then keeps it refreshed. After reset it holds the bus idle through the power-up settling time. It then runs a fixed command program: precharge all banks, load the mode register, eight auto-refreshes in two groups of four, and a second mode load. Ten read/write-back pairs to the lowest words follow to warm the device up. When they finish it raises a ready flag. From then on a two-stage timer asks for a group of four auto-refreshes at a fixed period.

Each command is presented on a 3-bit command code with an address bus. It stays there until the memory controller accepts it with `cmd_ack_i`. A size report from the sizing logic selects the refresh rate. A memory of 32 MB or less lets the prescaler drop to the slower divide ratio, which halves the refresh frequency. Larger or unreported memories keep the fast rate. All delays are computed from a clock-frequency parameter in MHz.

Top module: `sdram_init_refresh`

## Requirements
- R1: From reset release, `cmd_o` is NOP (code 0) for exactly CLK_MHZ*POWERUP_US cycles (10000 at the defaults). The first command after that is PRECHARGE-ALL (code 1) with only address bit 10 set (0x400).
- R2: The command after the precharge is MODE-REGISTER-SET (code 3). Its address carries the mode value 0x22 shifted left by two (0x088), because the two lowest address lines are not wired to the memory.
- R3: After each accepted command group there are exactly CLK_MHZ*GAP_US NOP cycles (100 at the defaults) before the next group starts. The groups are the precharge, each mode load, each refresh group of the init program, and the second mode load before warm-up.
- R4: After the first mode load come eight AUTO-REFRESH commands (code 2) as two back-to-back groups of four. A second MODE-REGISTER-SET with the same address 0x088 follows them.
- R5: After the second mode load come ten warm-up pairs, with no idle cycle inside or between pairs. Each pair is READ (code 4) then WRITE (code 5) to byte address 4*i, for i = 0..9 in ascending order.
- R6: `init_done_o` is low from reset through the last warm-up WRITE. It rises in the cycle after that WRITE is accepted and stays high until the next reset.
- R7: A command other than NOP holds its code and address unchanged while `cmd_ack_i` is low. The sequencer advances only on the clock edge where `cmd_ack_i` is high.
- R8: Periodic refreshes are never requested before `init_done_o` is high. The first periodic AUTO-REFRESH appears FAST_DIV*REFRESH_TICKS cycles (1560) after `init_done_o` rises, with every acknowledge immediate.
- R9: While running at the fast rate, each refresh request yields exactly four consecutive AUTO-REFRESH commands. Group starts are spaced FAST_DIV*REFRESH_TICKS = 1560 cycles apart.
- R10: A size report (`size_valid_i` high) with `size_mb_i` of 32 or less switches the refresh period to SLOW_DIV*REFRESH_TICKS = 3120 cycles, both during and after initialisation. A report of 33 or more leaves the fast rate. Once the slow rate is chosen it holds until reset, whatever is reported later.
- R11: While running, `cmd_o` is NOP in every cycle that is not part of a refresh group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_ack_i | input | 1 | Controller accepts the command now on `cmd_o` |
| size_valid_i | input | 1 | `size_mb_i` carries a valid memory size |
| size_mb_i | input | SIZE_W (10) | Detected memory size in megabytes |
| cmd_o | output | 3 | Command code: 0 NOP, 1 precharge-all, 2 auto-refresh, 3 mode set, 4 read, 5 write |
| addr_o | output | ADDR_W (13) | Address bus for the current command |
| init_done_o | output | 1 | Initialisation and warm-up complete |

## Verification
The init program runs at fixed offsets, so a wrong state, a miscounted group or a bad wait load shows at the ports as a wrong code, a wrong address or a wrong NOP run. It appears at the very next command boundary, at most one settling gap later. A refresh timer fault stays hidden until the first periodic group, which comes 1560 or 3120 cycles after the ready flag. The bench therefore measures whole start-to-start periods rather than single edges. A stuck or leaky rate latch shows only in the period after a size report, so the reports are placed at group starts and the following periods are measured.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_PRECHARGE = 3'd1,
    CMD_REFRESH   = 3'd2,
    CMD_MODESET   = 3'd3,
    CMD_READ      = 3'd4,
    CMD_WRITE     = 3'd5
  } sdram_cmd_e;

  typedef enum logic [3:0] {
    ST_POWERUP,
    ST_PRECHG,
    ST_GAP,
    ST_MODE1,
    ST_INITREF,
    ST_MODE2,
    ST_WARM_RD,
    ST_WARM_WR,
    ST_RUN,
    ST_RUNREF
  } seq_state_e;

  // Cycles in a delay given in microseconds at a clock given in MHz.
  function automatic int unsigned us_to_cycles(int unsigned mhz, int unsigned us);
    return mhz * us;
  endfunction

  // Clock cycles between two refresh requests.
  function automatic int unsigned refresh_period(int unsigned div, int unsigned ticks);
    return div * ticks;
  endfunction

  // Counter width able to hold values 0 .. n-1.
  function automatic int unsigned width_for(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Mode value as seen on the word-addressed bus (A0/A1 unwired).
  function automatic int unsigned mode_bus_word(int unsigned mode);
    return mode * 4;
  endfunction

  // Size class that allows the slow refresh rate.
  function automatic bit is_small_class(int unsigned size_mb, int unsigned limit_mb);
    return size_mb <= limit_mb;
  endfunction

endpackage

// File: rtl/sdram_delay_timer.sv
module sdram_delay_timer #(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned RESET_VAL = 9999
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RESET_VAL);
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  // A fresh load of a non-zero value must be counting, not expired.
  assert_load_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i != '0) |=> !expired_o);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer
  import sdram_seq_pkg::*;
#(
  parameter int unsigned FAST_DIV      = 8,
  parameter int unsigned SLOW_DIV      = 16,
  parameter int unsigned REFRESH_TICKS = 195
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic slow_i,
  output logic req_o
);

  localparam int unsigned PW = width_for(SLOW_DIV);
  localparam int unsigned TW = width_for(REFRESH_TICKS);

  logic [PW-1:0] pcnt_q;
  logic [TW-1:0] tcnt_q;
  logic [PW-1:0] div_last;
  logic          tick;
  logic          period_end;

  assign div_last   = slow_i ? PW'(SLOW_DIV - 1) : PW'(FAST_DIV - 1);
  assign tick       = en_i && (pcnt_q >= div_last);
  assign period_end = tick && (tcnt_q == TW'(REFRESH_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      tcnt_q <= '0;
    end else if (!en_i) begin
      pcnt_q <= '0;
      tcnt_q <= '0;
    end else if (tick) begin
      pcnt_q <= '0;
      tcnt_q <= period_end ? '0 : tcnt_q + 1'b1;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign req_o = period_end;

  // Requests are isolated pulses, a full period apart.
  assert_req_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned INIT_REFS  = 8,
  parameter int unsigned BURST_LEN  = 4,
  parameter int unsigned WARM_WORDS = 10,
  parameter int unsigned MODE_VAL   = 34,
  parameter int unsigned PRECHG_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_i,
  input  logic              wait_done_i,
  input  logic              refresh_req_i,
  output sdram_cmd_e        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wait_load_o,
  output logic              init_done_o
);

  localparam int unsigned INIT_BURSTS = INIT_REFS / BURST_LEN;
  localparam int unsigned POS_W = width_for(BURST_LEN);
  localparam int unsigned BN_W  = width_for(INIT_BURSTS);
  localparam int unsigned WI_W  = width_for(WARM_WORDS);
  localparam logic [ADDR_W-1:0] MODE_ADDR   = ADDR_W'(mode_bus_word(MODE_VAL));
  localparam logic [ADDR_W-1:0] PRECHG_ADDR = ADDR_W'(1) << PRECHG_BIT;

  seq_state_e       state_q;
  seq_state_e       after_q;
  logic [POS_W-1:0] burst_pos_q;
  logic [BN_W-1:0]  burst_no_q;
  logic [WI_W-1:0]  warm_idx_q;
  logic             pending_q;
  logic             done_q;

  // Named internal events.
  logic cmd_accept;
  logic last_in_burst;
  logic last_burst;
  logic last_warm;
  logic group_end;

  assign cmd_accept    = ack_i && (cmd_o != CMD_NOP);
  assign last_in_burst = (burst_pos_q == POS_W'(BURST_LEN - 1));
  assign last_burst    = (burst_no_q == BN_W'(INIT_BURSTS - 1));
  assign last_warm     = (warm_idx_q == WI_W'(WARM_WORDS - 1));
  assign group_end     = (state_q == ST_PRECHG) || (state_q == ST_MODE1) ||
                         (state_q == ST_MODE2) ||
                         ((state_q == ST_INITREF) && last_in_burst);
  assign wait_load_o   = cmd_accept && group_end;
  assign init_done_o   = done_q;

  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    unique case (state_q)
      ST_PRECHG: begin
        cmd_o  = CMD_PRECHARGE;
        addr_o = PRECHG_ADDR;
      end
      ST_MODE1, ST_MODE2: begin
        cmd_o  = CMD_MODESET;
        addr_o = MODE_ADDR;
      end
      ST_INITREF, ST_RUNREF: cmd_o = CMD_REFRESH;
      ST_WARM_RD: begin
        cmd_o  = CMD_READ;
        addr_o = ADDR_W'({warm_idx_q, 2'b00});
      end
      ST_WARM_WR: begin
        cmd_o  = CMD_WRITE;
        addr_o = ADDR_W'({warm_idx_q, 2'b00});
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_POWERUP;
      after_q     <= ST_PRECHG;
      burst_pos_q <= '0;
      burst_no_q  <= '0;
      warm_idx_q  <= '0;
      pending_q   <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      if (refresh_req_i && state_q != ST_RUN) pending_q <= 1'b1;
      unique case (state_q)
        ST_POWERUP: if (wait_done_i) state_q <= ST_PRECHG;
        ST_GAP:     if (wait_done_i) state_q <= after_q;
        ST_PRECHG: if (cmd_accept) begin
          state_q <= ST_GAP;
          after_q <= ST_MODE1;
        end
        ST_MODE1: if (cmd_accept) begin
          state_q <= ST_GAP;
          after_q <= ST_INITREF;
        end
        ST_INITREF: if (cmd_accept) begin
          if (last_in_burst) begin
            burst_pos_q <= '0;
            state_q     <= ST_GAP;
            if (last_burst) begin
              burst_no_q <= '0;
              after_q    <= ST_MODE2;
            end else begin
              burst_no_q <= burst_no_q + 1'b1;
              after_q    <= ST_INITREF;
            end
          end else begin
            burst_pos_q <= burst_pos_q + 1'b1;
          end
        end
        ST_MODE2: if (cmd_accept) begin
          state_q <= ST_GAP;
          after_q <= ST_WARM_RD;
        end
        ST_WARM_RD: if (cmd_accept) state_q <= ST_WARM_WR;
        ST_WARM_WR: if (cmd_accept) begin
          if (last_warm) begin
            state_q <= ST_RUN;
            done_q  <= 1'b1;
          end else begin
            warm_idx_q <= warm_idx_q + 1'b1;
            state_q    <= ST_WARM_RD;
          end
        end
        ST_RUN: if (refresh_req_i || pending_q) begin
          state_q   <= ST_RUNREF;
          pending_q <= 1'b0;
        end
        ST_RUNREF: if (cmd_accept) begin
          if (last_in_burst) begin
            burst_pos_q <= '0;
            state_q     <= ST_RUN;
          end else begin
            burst_pos_q <= burst_pos_q + 1'b1;
          end
        end
        default: state_q <= ST_POWERUP;
      endcase
    end
  end

  // A pending command keeps code and address until acknowledged.
  assert_cmd_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_NOP && !ack_i) |=> (cmd_o == $past(cmd_o) && addr_o == $past(addr_o)));

  // Ready, once reached, is kept.
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o);

  // Ready follows directly on an accepted warm-up write.
  assert_done_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done_o) |-> ($past(cmd_o) == CMD_WRITE && $past(ack_i)));

  // Closing a command group opens an idle gap.
  assert_gap_after_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wait_load_o |=> cmd_o == CMD_NOP);

  // The timer only asks for refreshes once the memory is ready.
  assert_refresh_only_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req_i |-> init_done_o);

endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
  import sdram_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 50,
  parameter int unsigned POWERUP_US    = 200,
  parameter int unsigned GAP_US        = 2,
  parameter int unsigned FAST_DIV      = 8,
  parameter int unsigned SLOW_DIV      = 16,
  parameter int unsigned REFRESH_TICKS = 195,
  parameter int unsigned INIT_REFS     = 8,
  parameter int unsigned BURST_LEN     = 4,
  parameter int unsigned WARM_WORDS    = 10,
  parameter int unsigned MODE_VAL      = 34,
  parameter int unsigned PRECHG_BIT    = 10,
  parameter int unsigned SMALL_MB      = 32,
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned SIZE_W        = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_ack_i,
  input  logic              size_valid_i,
  input  logic [SIZE_W-1:0] size_mb_i,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  localparam int unsigned POWERUP_CYC = us_to_cycles(CLK_MHZ, POWERUP_US);
  localparam int unsigned GAP_CYC     = us_to_cycles(CLK_MHZ, GAP_US);
  localparam int unsigned MAX_WAIT    = (POWERUP_CYC > GAP_CYC) ? POWERUP_CYC : GAP_CYC;
  localparam int unsigned CNT_W       = width_for(MAX_WAIT);

  sdram_cmd_e seq_cmd;
  logic       wait_load;
  logic       wait_done;
  logic       refresh_req;
  logic       slow_q;
  logic       small_report;

  assign small_report = size_valid_i && is_small_class(int'(size_mb_i), SMALL_MB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            slow_q <= 1'b0;
    else if (small_report) slow_q <= 1'b1;
  end

  sdram_delay_timer #(
    .CNT_W     (CNT_W),
    .RESET_VAL (POWERUP_CYC - 1)
  ) u_delay (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (wait_load),
    .load_val_i (CNT_W'(GAP_CYC - 1)),
    .expired_o  (wait_done)
  );

  sdram_refresh_timer #(
    .FAST_DIV      (FAST_DIV),
    .SLOW_DIV      (SLOW_DIV),
    .REFRESH_TICKS (REFRESH_TICKS)
  ) u_refresh (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (init_done_o),
    .slow_i (slow_q),
    .req_o  (refresh_req)
  );

  sdram_seq_fsm #(
    .ADDR_W     (ADDR_W),
    .INIT_REFS  (INIT_REFS),
    .BURST_LEN  (BURST_LEN),
    .WARM_WORDS (WARM_WORDS),
    .MODE_VAL   (MODE_VAL),
    .PRECHG_BIT (PRECHG_BIT)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .ack_i         (cmd_ack_i),
    .wait_done_i   (wait_done),
    .refresh_req_i (refresh_req),
    .cmd_o         (seq_cmd),
    .addr_o        (addr_o),
    .wait_load_o   (wait_load),
    .init_done_o   (init_done_o)
  );

  assign cmd_o = seq_cmd;

  // The slow refresh rate, once chosen, holds until reset.
  assert_rate_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    slow_q |=> slow_q);

  // A small-size report always leaves the slow rate selected.
  assert_small_selects_slow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    small_report |=> slow_q);

endmodule

// File: tb/tb_sdram_init_refresh.sv
module tb_sdram_init_refresh;

  localparam int CLK_MHZ   = 50;
  localparam int P         = CLK_MHZ * 200;
  localparam int G         = CLK_MHZ * 2;
  localparam int FAST      = 8 * 195;
  localparam int SLOW      = 16 * 195;
  localparam int NOP       = 0;
  localparam int PRE       = 1;
  localparam int REF       = 2;
  localparam int MRS       = 3;
  localparam int RD        = 4;
  localparam int WR        = 5;
  localparam int MODE_ADDR = 'h22 * 4;
  localparam int PRE_ADDR  = 1 << 10;

  // Expected init program: {command, address, NOP cycles before it}.
  localparam int INIT_TAB [11][3] = '{
    '{PRE, PRE_ADDR, P}, '{MRS, MODE_ADDR, G},
    '{REF, 0, G}, '{REF, 0, 0}, '{REF, 0, 0}, '{REF, 0, 0},
    '{REF, 0, G}, '{REF, 0, 0}, '{REF, 0, 0}, '{REF, 0, 0},
    '{MRS, MODE_ADDR, G}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack = 1'b1;
  logic        size_valid = 1'b0;
  logic [9:0]  size_mb = '0;
  logic [2:0]  cmd;
  logic [12:0] addr;
  logic        done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdram_init_refresh dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_ack_i    (ack),
    .size_valid_i (size_valid),
    .size_mb_i    (size_mb),
    .cmd_o        (cmd),
    .addr_o       (addr),
    .init_done_o  (done)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic next_cmd(output int nops, output int c, output int a);
    nops = 0;
    while (cmd == 3'd0) begin
      nops++;
      @(negedge clk);
    end
    c = cmd;
    a = addr;
    @(negedge clk);
  endtask

  task automatic apply_reset(input bit ack_v, input bit sv, input int mb);
    @(negedge clk);
    rst_n      = 1'b0;
    ack        = ack_v;
    size_valid = sv;
    size_mb    = 10'(mb);
    repeat (3) @(negedge clk);
    check("R1 reset command", cmd, NOP);
    check("R6 reset ready flag", done, 0);
    rst_n = 1'b1;
  endtask

  task automatic check_init(input int first);
    int n, c, a;
    check("R6 ready low during init", done, 0);
    for (int i = first; i < 11; i++) begin
      next_cmd(n, c, a);
      check(i == 0 ? "R1 power-up idle" : "R3 group gap", n, INIT_TAB[i][2]);
      check(i < 2 ? "R2 command order" : "R4 init command", c, INIT_TAB[i][0]);
      check(i == 1 || i == 10 ? "R2 mode address" : "R1 R4 address", a, INIT_TAB[i][1]);
    end
    for (int w = 0; w < 10; w++) begin
      next_cmd(n, c, a);
      check("R5 read gap", n, (w == 0) ? G : 0);
      check("R5 read command", c, RD);
      check("R5 read address", a, 4 * w);
      next_cmd(n, c, a);
      check("R5 write gap", n, 0);
      check("R5 write command", c, WR);
      check("R5 write address", a, 4 * w);
    end
    check("R6 ready after warm-up", done, 1);
  endtask

  task automatic first_refresh(input string tag, input int exp);
    int t = 0;
    while (cmd == 3'd0) begin
      t++;
      @(negedge clk);
    end
    check(tag, t, exp);
    check("R9 periodic command", cmd, REF);
  endtask

  task automatic burst_period(output int per);
    int ok = 1;
    for (int k = 0; k < 4; k++) begin
      if (cmd != 3'(REF)) ok = 0;
      @(negedge clk);
    end
    check("R9 group of four", ok, 1);
    per = 4;
    while (cmd == 3'd0) begin
      per++;
      @(negedge clk);
    end
  endtask

  initial begin
    int per;
    int t;
    int stable;

    // Fast rate, then size reports on both sides of the limit.
    apply_reset(1'b1, 1'b0, 0);
    check_init(0);
    first_refresh("R8 first periodic refresh", FAST);
    burst_period(per);
    check("R9 fast period", per, FAST);
    burst_period(per);
    check("R11 idle between groups", per, FAST);
    size_valid = 1'b1;
    size_mb    = 10'd33;
    burst_period(per);
    check("R10 above limit stays fast", per, FAST);
    size_mb = 10'd32;
    burst_period(per);
    burst_period(per);
    check("R10 small memory slows", per, SLOW);
    size_mb = 10'd100;
    burst_period(per);
    check("R10 slow rate sticky", per, SLOW);

    // Large memory reported during init keeps the fast rate.
    apply_reset(1'b1, 1'b1, 64);
    check_init(0);
    first_refresh("R8 first refresh large", FAST);
    burst_period(per);
    check("R10 large memory fast", per, FAST);

    // Acknowledge withheld; boundary size reported from reset.
    apply_reset(1'b0, 1'b1, 32);
    t = 0;
    while (cmd == 3'd0) begin
      t++;
      @(negedge clk);
    end
    check("R1 power-up idle held ack", t, P);
    stable = 1;
    for (int k = 0; k < 20; k++) begin
      if (cmd != 3'(PRE) || addr != 13'(PRE_ADDR)) stable = 0;
      @(negedge clk);
    end
    check("R7 held without ack", stable, 1);
    ack = 1'b1;
    @(negedge clk);
    check("R7 advances on ack", cmd, NOP);
    check_init(1);
    first_refresh("R10 boundary slow from init", SLOW);
    burst_period(per);
    check("R10 boundary slow period", per, SLOW);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule